// File: doc/BRIEF.md
# Aperture Address Remapping Translator

This block sits on a device-side address path and rewrites 32-bit bus addresses that land inside a programmable remapping window into 40-bit physical addresses. Addresses outside the window, or any address while the window is switched off, leave the block unchanged with eight zero bits on top. Inside the window, the 4 KB page index selects an entry in a small internal page table. The entry packs a 40-bit physical page into 32 bits: address bits 31:12 sit in the top of the word, and address bits 39:32 are folded into the low flag area. The byte offset is carried through untouched.

Software programs the window through two registers, a base register and a control register. It fills the table through a write port that takes a physical page number and does the packing itself. Pages at or above 1 TB are refused. An unmap write points an entry at a fixed scratch page instead of clearing it, so stray prefetches still reach harmless memory. A small direct-mapped cache keeps recently used entries. It is only trusted after a flush pulse that follows the last register write. A fetched entry whose valid bit is clear, or a page index past the end of the table, yields the scratch page and an error flag.

Top module: `aperture_xlat`

## Requirements
- R1: After reset, rsp_valid, xlat_ready and tbl_rej are 0, the window registers are 0 (window off), and every table entry is invalid.
- R2: The window base is cfg base register bits 14:0 times 32 MB. The size is 32 MB shifted left by control bits 3:1. Control bit 0 enables translation. cfg_sel=0 writes the base register and cfg_sel=1 writes the control register.
- R3: A window whose base plus size exceeds 4 GB is treated as absent, and all addresses pass through. A window ending exactly at 4 GB is valid.
- R4: A request accepted on one clock edge is answered with rsp_valid on the edge after the next. A miss or a disabled window returns {8'h00, req_addr} with rsp_hit=0, rsp_err=0 and rsp_cached=0.
- R5: A hit with a valid entry returns {entry[11:4], entry[31:12], req_addr[11:0]} with rsp_hit=1 and rsp_err=0. The page index is (req_addr - base) / 4096.
- R6: A map write stores {ppage[19:0], ppage[27:20], 4'b0011} (bit 0 valid, bit 1 coherent). A map write with any of ppage[35:28] set leaves the entry unchanged and raises tbl_rej for exactly the next cycle.
- R7: An unmap write stores the scratch page in the same encoding with the valid bit set. A hit on it returns the scratch page with rsp_err=0.
- R8: A hit whose entry has bit 0 clear, or whose page index is at or above TBL_DEPTH, returns {SCRATCH_PAGE, req_addr[11:0]} with rsp_err=1.
- R9: While xlat_ready is 1, a hit that reads a valid entry from the table fills the cache. Later hits on that page use the cached entry (rsp_cached=1), even if the table has since been rewritten.
- R10: A flush pulse invalidates every cached entry and sets xlat_ready on the following cycle. A flush that coincides with a fill cancels the fill.
- R11: Any register write clears xlat_ready. While xlat_ready is 0, no cache lookup hits and no fill takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 the control register |
| cfg_wdata | input | 15 | Register write data |
| tbl_we | input | 1 | Table write strobe |
| tbl_map | input | 1 | 1 maps to tbl_ppage, 0 unmaps to the scratch page |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_ppage | input | 36 | Physical page number (address bits 47:12) |
| flush | input | 1 | Cache flush pulse |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_addr | output | 40 | Translated or passed-through address |
| rsp_hit | output | 1 | The address fell inside the window |
| rsp_err | output | 1 | Invalid entry or index past the table |
| rsp_cached | output | 1 | The entry came from the cache |
| xlat_ready | output | 1 | Cache in use (flushed since the last register write) |
| tbl_rej | output | 1 | Previous map write was refused |

## Verification
The bench builds the block with TBL_DEPTH=16, CACHE_N=4 and a distinctive scratch page. With a 16-entry table, even the smallest 32 MB window runs far past the end of the table, so the out-of-range error path is easy to reach. With four cache sets, random traffic over 24 pages causes frequent evictions and tag conflicts. A cycle-accurate behavioural model is compared with every output on every clock. Directed phases cover:
- stale cached entries after a table rewrite;
- flush and register-write interplay;
- the 4 GB window limit;
- refused writes at or above 1 TB.

// File: rtl/aperture_xlat.sv
module aperture_xlat #(
  parameter int TBL_DEPTH = 64,
  parameter int CACHE_N = 4,
  parameter logic [27:0] SCRATCH_PAGE = 28'h0000100,
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [14:0]      cfg_wdata,
  input  logic             tbl_we,
  input  logic             tbl_map,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [35:0]      tbl_ppage,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  output logic             rsp_valid,
  output logic [39:0]      rsp_addr,
  output logic             rsp_hit,
  output logic             rsp_err,
  output logic             rsp_cached,
  output logic             xlat_ready,
  output logic             tbl_rej
);
  localparam int CS_W = (CACHE_N > 1) ? $clog2(CACHE_N) : 1;

  logic [14:0] base_q;
  logic [3:0]  ctrl_q;
  logic        ready_q;

  logic [31:0] mem [TBL_DEPTH];
  logic [31:0] tbl_q;

  logic [CACHE_N-1:0] c_val;
  logic [IDX_W-1:0]   c_tag [CACHE_N];
  logic [31:0]        c_ent [CACHE_N];

  logic             s1_v, s1_in, s1_ok, s1_hit;
  logic [31:0]      s1_ent;
  logic [31:0]      s1_addr;
  logic [IDX_W-1:0] s1_idx;

  // window decode, in 4 KB pages
  wire [27:0] base_pg = {base_q, 13'd0};
  wire [28:0] size_pg = 29'h0002000 << ctrl_q[3:1];
  wire [28:0] end_pg  = {1'b0, base_pg} + size_pg;
  wire        ap_on   = ctrl_q[0] && (end_pg <= 29'h0100000);
  wire [19:0] a_pg    = req_addr[31:12];
  wire        in_ap   = ap_on && ({8'd0, a_pg} >= base_pg) && ({9'd0, a_pg} < end_pg);
  wire [19:0] pidx    = a_pg - base_pg[19:0];
  wire        idx_ok  = {12'd0, pidx} < 32'(TBL_DEPTH);
  wire [IDX_W-1:0] idx  = pidx[IDX_W-1:0];
  wire [CS_W-1:0]  cset = idx[CS_W-1:0];
  wire        c_hit   = ready_q && in_ap && idx_ok && c_val[cset] && (c_tag[cset] == idx);

  // table write encoding
  wire        wr_bad = tbl_map && (tbl_ppage[35:28] != 8'd0);
  wire [31:0] wr_ent = tbl_map ? {tbl_ppage[19:0], tbl_ppage[27:20], 4'b0011}
                               : {SCRATCH_PAGE[19:0], SCRATCH_PAGE[27:20], 4'b0011};

  // response decode
  wire [31:0] ent    = s1_hit ? s1_ent : tbl_q;
  wire        good   = s1_ok && ent[0];
  wire [39:0] xl_out = !s1_in ? {8'd0, s1_addr}
                     : good   ? {ent[11:4], ent[31:12], s1_addr[11:0]}
                              : {SCRATCH_PAGE, s1_addr[11:0]};
  wire        fill   = s1_v && s1_in && s1_ok && !s1_hit && tbl_q[0] && ready_q && !flush;
  wire [CS_W-1:0] fset = s1_idx[CS_W-1:0];

  logic unused_ent_bits;
  assign unused_ent_bits = ^ent[3:1];

  assign xlat_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_DEPTH; i++) mem[i] <= '0;
    end else if (tbl_we && !wr_bad) begin
      mem[tbl_idx] <= wr_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      c_tag[fset] <= s1_idx;
      c_ent[fset] <= tbl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      ctrl_q     <= '0;
      ready_q    <= 1'b0;
      c_val      <= '0;
      tbl_q      <= '0;
      s1_v       <= 1'b0;
      s1_in      <= 1'b0;
      s1_ok      <= 1'b0;
      s1_hit     <= 1'b0;
      s1_ent     <= '0;
      s1_addr    <= '0;
      s1_idx     <= '0;
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_hit    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_cached <= 1'b0;
      tbl_rej    <= 1'b0;
    end else begin
      if (cfg_we && !cfg_sel) base_q <= cfg_wdata;
      if (cfg_we && cfg_sel)  ctrl_q <= cfg_wdata[3:0];

      if (cfg_we)     ready_q <= 1'b0;
      else if (flush) ready_q <= 1'b1;

      if (flush)     c_val       <= '0;
      else if (fill) c_val[fset] <= 1'b1;

      tbl_q   <= mem[idx];
      s1_v    <= req_valid;
      s1_in   <= in_ap;
      s1_ok   <= idx_ok;
      s1_hit  <= c_hit;
      s1_ent  <= c_ent[cset];
      s1_addr <= req_addr;
      s1_idx  <= idx;

      rsp_valid  <= s1_v;
      rsp_addr   <= xl_out;
      rsp_hit    <= s1_in;
      rsp_err    <= s1_in && !good;
      rsp_cached <= s1_in && s1_hit;
      tbl_rej    <= tbl_we && wr_bad;
    end
  end
endmodule

// File: rtl/aperture_xlat_chk.sv
module aperture_xlat_chk #(
  parameter logic [27:0] SCRATCH_PAGE = 28'h0000100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        flush,
  input logic        tbl_we,
  input logic        tbl_map,
  input logic [35:0] tbl_ppage,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic [39:0] rsp_addr,
  input logic        rsp_hit,
  input logic        rsp_err,
  input logic        rsp_cached,
  input logic        xlat_ready,
  input logic        tbl_rej
);
  a_r11_cfg_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !xlat_ready);

  a_r10_flush_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !cfg_we |=> xlat_ready);

  a_r6_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we && tbl_map && (tbl_ppage[35:28] != 8'd0) |=> tbl_rej);

  a_r6_no_spurious_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbl_we && tbl_map) |=> !tbl_rej);

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 rsp_valid);

  a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ##1 !rsp_valid);

  a_r4_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_addr[39:32] == 8'd0 && !rsp_err && !rsp_cached);

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[11:0] == $past(req_addr[11:0], 2));

  a_r8_err_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_hit && rsp_addr[39:12] == SCRATCH_PAGE);

  a_r9_cached_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cached |-> rsp_hit && !rsp_err);
endmodule

bind aperture_xlat aperture_xlat_chk #(.SCRATCH_PAGE(SCRATCH_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .flush(flush),
  .tbl_we(tbl_we), .tbl_map(tbl_map), .tbl_ppage(tbl_ppage),
  .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
  .rsp_err(rsp_err), .rsp_cached(rsp_cached), .xlat_ready(xlat_ready),
  .tbl_rej(tbl_rej)
);

// File: tb/aperture_xlat_tb.sv
module aperture_xlat_tb;
  localparam int DEPTH = 16;
  localparam int CN = 4;
  localparam logic [27:0] SCR = 28'h00ABCDE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [14:0] cfg_wdata = '0;
  logic tbl_we = 0, tbl_map = 0;
  logic [3:0] tbl_idx = '0;
  logic [35:0] tbl_ppage = '0;
  logic flush = 0, req_valid = 0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_err, rsp_cached, xlat_ready, tbl_rej;
  logic [39:0] rsp_addr;

  always #10 clk = ~clk;

  aperture_xlat #(.TBL_DEPTH(DEPTH), .CACHE_N(CN), .SCRATCH_PAGE(SCR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tbl_we(tbl_we), .tbl_map(tbl_map), .tbl_idx(tbl_idx), .tbl_ppage(tbl_ppage),
    .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_cached(rsp_cached), .xlat_ready(xlat_ready), .tbl_rej(tbl_rej));

  int checks = 0, errors = 0;
  bit chk_on = 0, done = 0;
  string tag = "R1";

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint m_base = 0, m_ctrl = 0;
  logic [31:0] m_mem [DEPTH];
  bit m_cv [CN];
  int m_ct [CN];
  logic [31:0] m_ce [CN];
  bit m_ready = 0;
  logic [31:0] m_tq = '0;
  bit s_v = 0, s_in = 0, s_ok = 0, s_hit = 0;
  logic [31:0] s_ent = '0;
  longint s_addr = 0;
  int s_idx = 0;
  bit e_v = 0, e_hit = 0, e_err = 0, e_cached = 0, e_rej = 0;
  longint e_addr = 0;

  function automatic logic [31:0] pack(longint pp);
    return 32'(((pp & 64'hFFFFF) << 12) | (((pp >> 20) & 64'hFF) << 4) | 64'h3);
  endfunction

  always @(posedge clk) begin : model
    longint base, sz, a;
    bit on, inap, ok, hit, good, fill;
    int pi, set, fset;
    logic [31:0] ent, ftq, nent, ntq;
    if (!rst_n) begin
      m_base = 0; m_ctrl = 0; m_ready = 0; m_tq = '0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      for (int i = 0; i < CN; i++) begin m_cv[i] = 0; m_ct[i] = 0; m_ce[i] = '0; end
      s_v = 0; s_in = 0; s_ok = 0; s_hit = 0; s_ent = '0; s_addr = 0; s_idx = 0;
      e_v = 0; e_hit = 0; e_err = 0; e_cached = 0; e_rej = 0; e_addr = 0;
    end else begin
      ent = s_hit ? s_ent : m_tq;
      good = s_ok && ent[0];
      e_v = s_v; e_hit = s_in; e_err = s_in && !good; e_cached = s_in && s_hit;
      if (!s_in) e_addr = s_addr;
      else if (good) e_addr = (longint'(ent[11:4]) << 32) | longint'(ent & 32'hFFFFF000) | (s_addr & 64'hFFF);
      else e_addr = (longint'(SCR) << 12) | (s_addr & 64'hFFF);
      fill = s_v && s_in && s_ok && !s_hit && m_tq[0] && m_ready && !flush;
      fset = s_idx % CN; ftq = m_tq;

      base = (m_base & 64'h7FFF) << 25;
      sz = 64'h2000000 << ((m_ctrl >> 1) & 7);
      on = m_ctrl[0] && (base + sz <= 64'h100000000);
      a = longint'(req_addr);
      inap = on && a >= base && a < base + sz;
      pi = inap ? int'((a - base) >> 12) : 0;
      ok = inap && pi < DEPTH;
      set = pi % CN;
      hit = m_ready && ok && m_cv[set] && m_ct[set] == pi;
      nent = m_ce[set];
      ntq = m_mem[pi % DEPTH];

      if (flush) for (int i = 0; i < CN; i++) m_cv[i] = 0;
      else if (fill) begin m_cv[fset] = 1; m_ct[fset] = s_idx; m_ce[fset] = ftq; end
      if (cfg_we) m_ready = 0; else if (flush) m_ready = 1;
      if (cfg_we && !cfg_sel) m_base = longint'(cfg_wdata);
      if (cfg_we && cfg_sel) m_ctrl = longint'(cfg_wdata & 15'hF);
      e_rej = tbl_we && tbl_map && (tbl_ppage[35:28] != 0);
      if (tbl_we && !e_rej) m_mem[tbl_idx] = tbl_map ? pack(longint'(tbl_ppage)) : pack(longint'(SCR));
      m_tq = ntq;
      s_v = req_valid; s_in = inap; s_ok = ok; s_hit = hit; s_ent = nent; s_addr = a; s_idx = pi;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R4", "rsp_valid", longint'(rsp_valid), longint'(e_v));
      check("R10", "xlat_ready", longint'(xlat_ready), longint'(m_ready));
      check("R6", "tbl_rej", longint'(tbl_rej), longint'(e_rej));
      if (e_v) begin
        check(tag, "rsp_addr", longint'(rsp_addr), e_addr);
        check("R8", "rsp_err", longint'(rsp_err), longint'(e_err));
        check("R2", "rsp_hit", longint'(rsp_hit), longint'(e_hit));
        check("R9", "rsp_cached", longint'(rsp_cached), longint'(e_cached));
      end
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic idle(int n); repeat (n) cyc(); endtask
  task automatic cfg(bit sel, int v);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = 15'(v); cyc(); cfg_we = 0;
  endtask
  task automatic twr(int idx, bit map, longint pp);
    tbl_we = 1; tbl_map = map; tbl_idx = 4'(idx); tbl_ppage = 36'(pp); cyc(); tbl_we = 0;
  endtask
  task automatic do_flush(); flush = 1; cyc(); flush = 0; endtask
  task automatic req(longint a);
    req_valid = 1; req_addr = 32'(a); cyc(); req_valid = 0;
  endtask

  initial begin
    repeat (3) cyc();
    check("R1", "reset rsp_valid", longint'(rsp_valid), 0);
    check("R1", "reset xlat_ready", longint'(xlat_ready), 0);
    check("R1", "reset tbl_rej", longint'(tbl_rej), 0);
    rst_n = 1; chk_on = 1;
    cyc();

    tag = "R4";
    req(32'h80001234); req(32'h12345678); req(32'hFFFFFFFF); idle(3);

    tag = "R2";
    cfg(0, 15'h40); cfg(1, 4'b0001); do_flush();
    tag = "R1";
    req(32'h80003ABC); idle(3);

    tag = "R6";
    twr(0, 1, 36'h0AB12345); twr(1, 1, 36'h000000001); twr(2, 1, 36'h00FFFFFFF);
    twr(3, 1, 36'h000800000); twr(4, 1, 36'h001234567); twr(5, 1, 36'h00055AA55);
    twr(6, 1, 36'h100000000); twr(4, 1, 36'hF00000001); idle(2);

    tag = "R5";
    for (int i = 0; i < 6; i++) req(32'h80000000 + i * 4096 + i * 17);
    idle(3);
    tag = "R9";
    for (int i = 0; i < 6; i++) req(32'h80000FFF + i * 4096);
    idle(3);
    twr(1, 1, 36'h000077777); req(32'h80001010); idle(3);
    tag = "R10";
    do_flush(); req(32'h80001010); req(32'h80001020); idle(3);

    tag = "R7";
    twr(2, 0, 0); do_flush(); req(32'h80002345); idle(3);
    tag = "R8";
    req(32'h80007000); req(32'h80014ABC); req(32'h80006001); idle(3);

    tag = "R11";
    req(32'h80000000); idle(3);
    cfg(1, 4'b0001); req(32'h80000100); req(32'h80000200); idle(3);
    do_flush(); req(32'h80000300); idle(1); req(32'h80000400); idle(3);

    tag = "R2";
    cfg(0, 15'h20); cfg(1, 4'b0111); do_flush();
    req(32'h40000000); req(32'h4FFFFFFF); req(32'h50000000); req(32'h3FFFFFFF); idle(3);

    tag = "R3";
    cfg(0, 15'h7F); cfg(1, 4'b0011); do_flush();
    req(32'hFE000010); idle(3);
    cfg(1, 4'b0001); do_flush();
    req(32'hFE000010); req(32'hFFFFF123); idle(3);
    tag = "R4";
    cfg(1, 4'b0000); req(32'hFE000010); idle(3);

    tag = "R5";
    cfg(0, 15'h40); cfg(1, 4'b0001); do_flush();
    for (int n = 0; n < 400; n++) begin
      req_valid = ($urandom % 10) < 7;
      req_addr = (($urandom % 10) == 0) ? $urandom
               : 32'h80000000 + ($urandom % 24) * 4096 + ($urandom % 4096);
      tbl_we = ($urandom % 10) == 0;
      tbl_map = ($urandom % 4) != 0;
      tbl_idx = 4'($urandom);
      tbl_ppage = (($urandom % 8) == 0) ? 36'h100000000 | 36'($urandom) : 36'($urandom % 32'h10000000);
      flush = ($urandom % 20) == 0;
      cyc();
    end
    req_valid = 0; tbl_we = 0; flush = 0;
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule